// File: doc/BRIEF.md
# Active Exception Completion Tracker

This block holds one active bit and one pending bit for every exception number of a small interrupt controller. Three request ports act on those bits: an acknowledge marks an exception as being serviced, a set-pending raises its pending bit, and a completion retires it. Priority arbitration and vector fetch belong to the surrounding controller. This block only keeps the bit vectors and judges completions.

Each completion request names an exception number. The tracker returns a registered two-bit status with a one-cycle done strobe. The status is one of three values. The request is illegal when the number is out of range or the exception is not active. The exit returns to base level when it was the only active exception. The exit is nested when other exceptions stay active. A legal completion clears the active bit. If the source is level-sensitive and its line is still high, its pending bit is set again so that the controller takes it once more.

Which sources are level-sensitive is fixed by a parameter mask. Exception numbers that are valid for every request lie strictly above the reset number and strictly below the configured exception count.

Top module: `exc_completion_tracker`

## Requirements
- R1: When reset is high at a clock edge, the active vector, the pending vector, the done strobe and the status all become zero.
- R2: An acknowledge for a number in range (greater than RESET_NUM = 1 and less than NUM_EXC = 12) sets that active bit and clears that pending bit at the next edge. An acknowledge for a number out of range has no effect.
- R3: A set-pending request for a number in range sets that pending bit at the next edge. One for a number out of range has no effect.
- R4: A completion for a number out of range, or for an exception whose active bit is clear, reports status 2'b11 (illegal) and changes no active or pending bit.
- R5: A legal completion reports 2'b01 (returned to base) when its exception was the only active bit before the edge. Otherwise it reports 2'b00 (still nested). The count is taken before the bit is cleared.
- R6: A legal completion clears the active bit of its exception at the same edge that registers the status.
- R7: On a legal completion of a source whose bit in LEVEL_MASK (default 12'hF30, bits 4, 5, 8, 9, 10 and 11) is 1 and whose line level input is high, the pending bit is set. A source that is edge-sensitive, or whose line is low, keeps its pending bit unchanged.
- R8: The done strobe is high for exactly the one cycle after each cycle with a completion request. The status only changes in those cycles, and 2'b10 never appears.
- R9: Requests in the same cycle combine. A completion is judged on the vectors before the edge. An acknowledge's set of the active bit wins over a completion's clear. An acknowledge's clear of the pending bit wins over set-pending and over a re-pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge request |
| ack_num | input | 4 | Exception number to acknowledge |
| setpend_valid | input | 1 | Set-pending request |
| setpend_num | input | 4 | Exception number to make pending |
| cmp_valid | input | 1 | Completion request |
| cmp_num | input | 4 | Exception number to complete |
| line_level | input | 12 | Current level of each source line |
| done_o | output | 1 | One-cycle strobe: status holds a new result |
| status_o | output | 2 | 11 illegal, 01 returned to base, 00 still nested |
| pending_o | output | 12 | Pending bit per exception |
| active_o | output | 12 | Active bit per exception |

## Verification
The assertions assume that every input stays at zero while reset is high. This keeps the first cycle after reset free of stale requests. They also assume that an acknowledge and a completion may name the same number in one cycle, and they exclude only those overlaps from the clear checks.

The stimulus holds all valid strobes low during reset. It then draws random numbers over the full 4-bit field, so out-of-range values and the reset number occur often. Half of the completions target an exception known to be active, so that both legal and illegal exits occur with nesting depths of one and more.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;
  typedef enum logic [1:0] {
    ST_NESTED  = 2'b00,
    ST_BASE    = 2'b01,
    ST_ILLEGAL = 2'b11
  } cmp_status_e;
endpackage

// File: rtl/exc_num_decode.sv
module exc_num_decode #(
  parameter int NUM_EXC   = 12,
  parameter int RESET_NUM = 1,
  parameter int NW        = $clog2(NUM_EXC)
) (
  input  logic               req_valid,
  input  logic [NW-1:0]      req_num,
  output logic [NUM_EXC-1:0] req_oh,
  output logic               in_range
);
  assign in_range = (int'(req_num) > RESET_NUM) && (int'(req_num) < NUM_EXC);

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_bit
    if (i > RESET_NUM) begin : g_live
      assign req_oh[i] = req_valid && (int'(req_num) == i);
    end else begin : g_dead
      assign req_oh[i] = 1'b0;
    end
  end
endmodule

// File: rtl/exc_cmp_eval.sv
module exc_cmp_eval
  import exc_trk_pkg::*;
#(
  parameter int NUM_EXC = 12
) (
  input  logic               cmp_valid,
  input  logic               cmp_in_range,
  input  logic [NUM_EXC-1:0] cmp_oh,
  input  logic [NUM_EXC-1:0] active_q,
  output logic               legal,
  output cmp_status_e        status_next
);
  logic only_one;

  assign legal    = cmp_valid && cmp_in_range && (|(cmp_oh & active_q));
  assign only_one = ($countones(active_q) == 1);

  always_comb begin
    if (!legal)        status_next = ST_ILLEGAL;
    else if (only_one) status_next = ST_BASE;
    else               status_next = ST_NESTED;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int NUM_EXC = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] ack_oh,
  input  logic [NUM_EXC-1:0] sp_oh,
  input  logic [NUM_EXC-1:0] clr_oh,
  input  logic [NUM_EXC-1:0] repend_oh,
  output logic [NUM_EXC-1:0] active_q,
  output logic [NUM_EXC-1:0] pending_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= '0;
      pending_q <= '0;
    end else begin
      active_q  <= (active_q & ~clr_oh) | ack_oh;
      pending_q <= (pending_q | sp_oh | repend_oh) & ~ack_oh;
    end
  end
endmodule

// File: rtl/exc_completion_tracker.sv
module exc_completion_tracker
  import exc_trk_pkg::*;
#(
  parameter int               NUM_EXC    = 12,
  parameter int               RESET_NUM  = 1,
  parameter logic [NUM_EXC-1:0] LEVEL_MASK = 12'hF30,
  localparam int              NW         = $clog2(NUM_EXC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_valid,
  input  logic [NW-1:0]      ack_num,
  input  logic               setpend_valid,
  input  logic [NW-1:0]      setpend_num,
  input  logic               cmp_valid,
  input  logic [NW-1:0]      cmp_num,
  input  logic [NUM_EXC-1:0] line_level,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic [NUM_EXC-1:0] pending_o,
  output logic [NUM_EXC-1:0] active_o
);
  logic [NUM_EXC-1:0] ack_oh, sp_oh, cmp_oh, clr_oh, repend_oh;
  logic               ack_rng, sp_rng, cmp_rng, legal;
  cmp_status_e        status_next;
  cmp_status_e        status_q;

  exc_num_decode #(.NUM_EXC(NUM_EXC), .RESET_NUM(RESET_NUM), .NW(NW)) u_dec_ack (
    .req_valid(ack_valid), .req_num(ack_num), .req_oh(ack_oh), .in_range(ack_rng));
  exc_num_decode #(.NUM_EXC(NUM_EXC), .RESET_NUM(RESET_NUM), .NW(NW)) u_dec_sp (
    .req_valid(setpend_valid), .req_num(setpend_num), .req_oh(sp_oh), .in_range(sp_rng));
  exc_num_decode #(.NUM_EXC(NUM_EXC), .RESET_NUM(RESET_NUM), .NW(NW)) u_dec_cmp (
    .req_valid(cmp_valid), .req_num(cmp_num), .req_oh(cmp_oh), .in_range(cmp_rng));

  exc_cmp_eval #(.NUM_EXC(NUM_EXC)) u_eval (
    .cmp_valid(cmp_valid), .cmp_in_range(cmp_rng), .cmp_oh(cmp_oh),
    .active_q(active_o), .legal(legal), .status_next(status_next));

  assign clr_oh    = legal ? cmp_oh : '0;
  assign repend_oh = clr_oh & LEVEL_MASK & line_level;

  exc_state_regs #(.NUM_EXC(NUM_EXC)) u_state (
    .clk(clk), .rst(rst), .ack_oh(ack_oh), .sp_oh(sp_oh), .clr_oh(clr_oh),
    .repend_oh(repend_oh), .active_q(active_o), .pending_q(pending_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      status_q <= ST_NESTED;
    end else begin
      done_o <= cmp_valid;
      if (cmp_valid) status_q <= status_next;
    end
  end
  assign status_o = status_q;

  // R2: acknowledge marks active and drops pending
  assert_ack_sets_active_R2: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_rng) |=> (((active_o & $past(ack_oh)) == $past(ack_oh)) &&
                                ((pending_o & $past(ack_oh)) == '0)));

  // R3: set-pending raises pending unless an acknowledge hits the same bit
  assert_setpend_R3: assert property (@(posedge clk) disable iff (rst)
    (setpend_valid && sp_rng && !(|(sp_oh & ack_oh))) |=>
      ((pending_o & $past(sp_oh)) == $past(sp_oh)));

  // R4: an illegal completion alone leaves both vectors untouched
  assert_illegal_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !legal && !ack_valid && !setpend_valid) |=>
      ($stable(active_o) && $stable(pending_o) && status_o == 2'b11));

  // R5: return-to-base only when exactly one exception was active
  assert_base_one_active_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == 2'b01) |-> ($countones($past(active_o)) == 1));

  // R6: legal completion clears its active bit unless re-acknowledged
  assert_clear_active_R6: assert property (@(posedge clk) disable iff (rst)
    (legal && !(|(cmp_oh & ack_oh))) |=> ((active_o & $past(clr_oh)) == '0));

  // R7: still-high level source is pending again
  assert_repend_R7: assert property (@(posedge clk) disable iff (rst)
    (|(repend_oh & ~ack_oh)) |=>
      ((pending_o & $past(repend_oh & ~ack_oh)) == $past(repend_oh & ~ack_oh)));

  // R8: done strobe follows each completion request by one cycle
  assert_done_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> (!done_o && $stable(status_o)));
  assert_status_code_R8: assert property (@(posedge clk) disable iff (rst)
    status_o != 2'b10);
endmodule

// File: tb/exc_completion_tracker_tb_top.sv
module exc_completion_tracker_tb_top;
  localparam int N = 12;
  localparam logic [N-1:0] LMASK = 12'hF30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_valid = 0, setpend_valid = 0, cmp_valid = 0;
  logic [3:0] ack_num = 0, setpend_num = 0, cmp_num = 0;
  logic [N-1:0] line_level = '0;
  logic done_o;
  logic [1:0] status_o;
  logic [N-1:0] pending_o, active_o;

  int n_checks = 0, n_fail = 0;
  logic [N-1:0] m_act = '0, m_pend = '0;
  logic [1:0] m_stat = 2'b00;
  bit finished = 0;

  always #2 clk = ~clk;

  exc_completion_tracker #(.NUM_EXC(N), .RESET_NUM(1), .LEVEL_MASK(LMASK)) dut_i (
    .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_num(ack_num),
    .setpend_valid(setpend_valid), .setpend_num(setpend_num),
    .cmp_valid(cmp_valid), .cmp_num(cmp_num), .line_level(line_level),
    .done_o(done_o), .status_o(status_o), .pending_o(pending_o), .active_o(active_o));

  function automatic logic [N-1:0] oh(input logic v, input int n);
    if (v && n > 1 && n < N) return N'(1) << n;
    return '0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, compare at the following falling edge
  task automatic step(input logic av, input int an, input logic sv, input int sn,
                      input logic cv, input int cn, input logic [N-1:0] lvl,
                      input string req);
    logic [N-1:0] ack, sp, clr, rep, nact, npend;
    logic legal;
    ack_valid = av; ack_num = 4'(an);
    setpend_valid = sv; setpend_num = 4'(sn);
    cmp_valid = cv; cmp_num = 4'(cn); line_level = lvl;
    ack = oh(av, an); sp = oh(sv, sn);
    legal = (oh(cv, cn) & m_act) != '0;
    clr = legal ? oh(cv, cn) : '0;
    rep = clr & LMASK & lvl;
    if (cv) m_stat = !legal ? 2'b11 : (($countones(m_act) == 1) ? 2'b01 : 2'b00);
    nact  = (m_act & ~clr) | ack;
    npend = (m_pend | sp | rep) & ~ack;
    @(negedge clk);
    chk(active_o == nact, req, "active", 32'(active_o), 32'(nact));
    chk(pending_o == npend, req, "pending", 32'(pending_o), 32'(npend));
    chk(done_o == cv, {req, " R8"}, "done", 32'(done_o), 32'(cv));
    chk(status_o == m_stat, req, "status", 32'(status_o), 32'(m_stat));
    m_act = nact; m_pend = npend;
    ack_valid = 0; setpend_valid = 0; cmp_valid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int pick;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(active_o == '0 && pending_o == '0, "R1", "reset vectors",
        32'({active_o, pending_o}), 0);
    chk(done_o == 1'b0 && status_o == 2'b00, "R1", "reset status",
        32'({done_o, status_o}), 0);

    // R4: completing inactive, reset number and out-of-range numbers
    step(0, 0, 0, 0, 1, 3, '1, "R4 inactive");
    step(0, 0, 0, 0, 1, 1, '1, "R4 reset number");
    step(0, 0, 0, 0, 1, 13, '1, "R4 out of range");
    // R2/R3: out-of-range acknowledge and set-pending ignored
    step(1, 0, 1, 14, 0, 0, '0, "R2 R3 out of range");
    step(0, 0, 1, 3, 0, 0, '0, "R3 setpend");
    step(1, 3, 0, 0, 0, 0, '0, "R2 ack");
    step(1, 5, 0, 0, 0, 0, '0, "R2 ack second");
    // R5 nested, then base
    step(0, 0, 0, 0, 1, 5, '0, "R5 R6 nested");
    step(0, 0, 0, 0, 0, 0, '0, "R8 idle hold");
    step(0, 0, 0, 0, 1, 3, 12'h008, "R5 R6 R7 base edge-line");
    step(0, 0, 0, 0, 1, 3, '0, "R4 double completion");
    // R7: level source with line high re-pends; low line does not
    step(1, 8, 0, 0, 0, 0, '0, "R2 ack level");
    step(0, 0, 0, 0, 1, 8, 12'h100, "R7 repend");
    step(1, 9, 0, 0, 0, 0, '0, "R2 ack level 9");
    step(0, 0, 0, 0, 1, 9, '0, "R7 low line");
    // R9: concurrent ack and completion of the same number
    step(1, 10, 0, 0, 0, 0, '0, "R2 ack 10");
    step(1, 10, 1, 10, 1, 10, 12'h400, "R9 ack wins");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int cn;
      pick = int'($urandom % 2);
      cn = int'($urandom % 16);
      if (pick == 1 && m_act != '0) begin
        for (int k = 0; k < 16; k++) begin
          if (k < N && m_act[k]) begin cn = k; if ($urandom % 2 == 0) break; end
        end
      end
      step(($urandom % 3) == 0, int'($urandom % 16),
           ($urandom % 4) == 0, int'($urandom % 16),
           ($urandom % 3) == 0, cn, N'($urandom),
           "R2 R3 R4 R5 R6 R7 R9 random");
    end
    // R1: reset from a busy state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_act = '0; m_pend = '0; m_stat = 2'b00;
    chk(active_o == '0 && pending_o == '0 && done_o == 0 && status_o == 0,
        "R1", "reset again", 32'({done_o, status_o, active_o, pending_o}), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule